// File: doc/BRIEF.md
# Folded Cyclic-Prefix Symbol Synchronizer

This block locates the start of an OFDM symbol in a stream of real-valued received samples that arrives at one sample per clock. Each OFDM symbol is an FFT body of `FFT_N` samples preceded by a cyclic prefix of `CP_LEN` samples, which copies the body's tail. The block multiplies every sample by the sample `FFT_N` positions earlier and keeps a sliding sum of these products over a window of `CP_LEN` products. This gives one correlation value per window start. The correlation is largest where the window lines up with a prefix and its copy.

A small FFT gives a short prefix, so a single symbol's correlation is noisy. The block therefore folds the correlation over `FOLD_K` consecutive symbol periods. It adds the values that share a position modulo the symbol length into a one-symbol accumulator. During the last fold pass, a comparator tracks the position whose folded value has the largest magnitude. The block is used only while the receiver acquires timing. A start strobe begins an acquisition. When the block raises its done flag, the reported index is the symbol-start position modulo the symbol length, counted from the first sample accepted after the strobe.

Top module: `fsync_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `acq_done` is 0 and `sym_start_idx` is 0.
- R2: `acq_start` clears all history and begins an acquisition. The sample presented in the strobe cycle is ignored. Sample number 0 is the first sample presented in a later cycle, and each later cycle accepts exactly one sample.
- R3: For a window start m, the correlation is g(m) = sum over j = 0..CP_LEN-1 of y[m+j]·y[m+j+FFT_N], computed on signed two's-complement samples with full product and sum width.
- R4: The folded metric for position p (0 ≤ p < SYM_LEN, with SYM_LEN = FFT_N + CP_LEN) is F(p) = sum over f = 0..FOLD_K-1 of g(p + f·SYM_LEN). A strong correlation in any single fold pass counts fully toward F(p).
- R5: The reported index is the p with the largest |F(p)|. A strongly negative F counts as much as a positive one. On equal magnitudes the smallest p wins.
- R6: `acq_done` rises on the clock edge that accepts sample number FFT_N + CP_LEN − 2 + FOLD_K·SYM_LEN (158 with the defaults) and stays 0 before that.
- R7: Once `acq_done` is 1, further samples are ignored. `acq_done` and `sym_start_idx` hold until the next `acq_start`.
- R8: An `acq_start` during an acquisition discards it, drops `acq_done` to 0 and restarts from sample 0.
- R9: Full-scale inputs (every sample at −2^(SAMP_W−1)) produce no overflow. The folded metric stays exact, and the all-equal metric resolves to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_start | input | 1 | Strobe that clears the block and starts acquisition |
| smp_in | input | SAMP_W (8) | Signed real received sample, one per clock |
| sym_start_idx | output | $clog2(FFT_N+CP_LEN) (6) | Detected symbol-start position modulo the symbol length |
| acq_done | output | 1 | High once FOLD_K symbol periods have been folded |

## Verification
Several corner cases get directed stimulus. A prefix copied with inverted sign yields a negative peak, which a design comparing signed values rather than magnitudes would miss. A constant stream makes every position tie, and a design using greater-or-equal would report the last position instead of 0. A strong peak that occurs only in the first fold pass must win over a weaker peak repeated in later passes; a design that folded wrongly or compared only the last pass would report the later peak. The done cycle is checked at the exact sample count, which catches an off-by-one in the lead-in or phase counting. Samples sent after done, a restart in mid-acquisition and full-scale negative input check that state holds, that it clears, and that the widths do not wrap.

// File: rtl/fsync_pkg.sv
// Shared types for the folded symbol synchronizer.
package fsync_pkg;

    // Acquisition control state.
    typedef enum logic {
        ACQ_IDLE = 1'b0,
        ACQ_RUN  = 1'b1
    } acq_state_e;

endpackage

// File: rtl/fsync_corr.sv
// Lag correlator with a sliding window.
// Multiplies each accepted sample by the sample LAG positions earlier
// (one multiplier) and keeps a running sum over the last WIN products.
// The sum is kept by adding the newest product and removing the one
// that leaves the window. corr_out is combinational and holds the sum
// that includes the current product.
// Assumes: clr zeroes the history, so products that use samples from
// before the acquisition are zero.
module fsync_corr #(
    parameter int SAMP_W = 8,
    parameter int LAG    = 32,
    parameter int WIN    = 8,
    parameter int SUM_W  = 2*SAMP_W + $clog2(WIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic signed [SAMP_W-1:0] sample_in,
    output logic signed [SUM_W-1:0]  corr_out
);
    localparam int PROD_W = 2*SAMP_W;

    logic signed [SAMP_W-1:0] sdl [LAG];
    logic signed [PROD_W-1:0] pdl [WIN];
    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  run_sum;

    // Single multiplier: the new sample times the sample LAG earlier.
    always_comb prod = sample_in * sdl[LAG-1];

    // Updated sum: add the new product, drop the oldest.
    always_comb corr_out = run_sum + SUM_W'(prod) - SUM_W'(pdl[WIN-1]);

    // Head of the sample line, head of the product line, and the sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sdl[0]  <= '0;
            pdl[0]  <= '0;
            run_sum <= '0;
        end else if (en) begin
            sdl[0]  <= sample_in;
            pdl[0]  <= prod;
            run_sum <= corr_out;
        end
    end

    // Stages of the sample delay line.
    for (genvar s = 1; s < LAG; s++) begin : g_sdl
        // Shift the sample history by one stage.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) sdl[s] <= '0;
            else if (en)       sdl[s] <= sdl[s-1];
        end
    end

    // Stages of the product delay line.
    for (genvar s = 1; s < WIN; s++) begin : g_pdl
        // Shift the product history by one stage.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) pdl[s] <= '0;
            else if (en)       pdl[s] <= pdl[s-1];
        end
    end

    // R2: a clear leaves an empty window.
    a_r2_clear_empties_window: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (run_sum == '0 && pdl[WIN-1] == '0 && sdl[LAG-1] == '0));

    // R3: with no acceptance the window sum does not move.
    a_r3_sum_stable_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(run_sum));

endmodule

// File: rtl/fsync_fold.sv
// Fold accumulator of one symbol length.
// Adds each correlation value to the entry for its phase, so that
// values SYM_LEN apart add up. fold_out is the updated entry value.
// Assumes: phase runs 0..SYM_LEN-1 and clr precedes every acquisition.
module fsync_fold #(
    parameter int SYM_LEN = 40,
    parameter int IN_W    = 19,
    parameter int FOLD_W  = 21,
    parameter int PH_W    = $clog2(SYM_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic [PH_W-1:0]         phase,
    input  logic signed [IN_W-1:0]  corr_in,
    output logic signed [FOLD_W-1:0] fold_out
);
    logic signed [FOLD_W-1:0] acc [SYM_LEN];

    // Sum of the stored entry and the new correlation value.
    always_comb fold_out = acc[phase] + FOLD_W'(corr_in);

    // Clear every entry on start, write back the sum when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int e = 0; e < SYM_LEN; e++) acc[e] <= '0;
        end else if (en) begin
            acc[phase] <= fold_out;
        end
    end

    // R4: the phase that addresses the buffer stays inside the symbol.
    a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (int'(phase) < SYM_LEN));

    // R4: a clear empties both ends of the buffer.
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc[0] == '0 && acc[SYM_LEN-1] == '0));

endmodule

// File: rtl/fsync_peak.sv
// Peak picker on the folded metric.
// Tracks the largest magnitude seen since the last clear and its phase.
// The first enabled value is always taken. After that, only a strictly
// larger magnitude replaces the stored one, so the earliest phase wins
// ties.
// Assumes: phases arrive in increasing order within one pass.
module fsync_peak #(
    parameter int VAL_W   = 21,
    parameter int SYM_LEN = 40,
    parameter int PH_W    = $clog2(SYM_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic [PH_W-1:0]         phase,
    input  logic signed [VAL_W-1:0] val,
    output logic [PH_W-1:0]         peak_idx
);
    logic [VAL_W-1:0] mag;
    logic [VAL_W-1:0] best_mag;
    logic             seen;

    // Magnitude as unsigned; the negated most negative value stays exact.
    always_comb mag = $unsigned(val[VAL_W-1] ? -val : val);

    // Keep the best magnitude and the phase where it occurred.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_mag <= '0;
            peak_idx <= '0;
            seen     <= 1'b0;
        end else if (en && (!seen || mag > best_mag)) begin
            best_mag <= mag;
            peak_idx <= phase;
            seen     <= 1'b1;
        end
    end

    // R5: the stored best magnitude never shrinks between clears.
    a_r5_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> best_mag >= $past(best_mag));

    // R5: the reported index always names a position inside one symbol.
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(peak_idx) < SYM_LEN);

endmodule

// File: rtl/fsync_top.sv
// Folded cyclic-prefix symbol synchronizer, top level.
// Sequences one acquisition: accepts one sample per clock after a start
// strobe, waits out the lead-in until the first full correlation window,
// then folds FOLD_K symbol periods and picks the peak in the last pass.
// Assumes: real signed samples, continuous one per clock while running.
module fsync_top #(
    parameter int SAMP_W  = 8,
    parameter int FFT_N   = 32,
    parameter int CP_LEN  = 8,
    parameter int FOLD_K  = 3,
    localparam int SYM_LEN = FFT_N + CP_LEN,
    localparam int PH_W    = $clog2(SYM_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acq_start,
    input  logic signed [SAMP_W-1:0] smp_in,
    output logic [PH_W-1:0]          sym_start_idx,
    output logic                     acq_done
);
    import fsync_pkg::*;

    localparam int LEAD   = FFT_N + CP_LEN - 1;
    localparam int LEAD_W = $clog2(LEAD + 1);
    localparam int PASS_W = $clog2(FOLD_K + 1);
    localparam int SUM_W  = 2*SAMP_W + $clog2(CP_LEN);
    localparam int FOLD_W = SUM_W + $clog2(FOLD_K);

    acq_state_e               state;
    logic [LEAD_W-1:0]        lead_cnt;
    logic [PH_W-1:0]          phase;
    logic [PASS_W-1:0]        pass;
    logic                     accept;
    logic                     corr_valid;
    logic                     last_pass;
    logic                     final_pt;
    logic signed [SUM_W-1:0]  corr;
    logic signed [FOLD_W-1:0] folded;

    // Decode this cycle's role in the acquisition.
    always_comb begin
        accept     = (state == ACQ_RUN) && !acq_start;
        corr_valid = accept && (lead_cnt == LEAD_W'(LEAD));
        last_pass  = (pass == PASS_W'(FOLD_K - 1));
        final_pt   = corr_valid && last_pass && (phase == PH_W'(SYM_LEN - 1));
    end

    // Acquisition sequencer: lead-in, phase and pass counters, done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ACQ_IDLE;
            lead_cnt <= '0;
            phase    <= '0;
            pass     <= '0;
            acq_done <= 1'b0;
        end else if (acq_start) begin
            state    <= ACQ_RUN;
            lead_cnt <= '0;
            phase    <= '0;
            pass     <= '0;
            acq_done <= 1'b0;
        end else if (accept) begin
            if (lead_cnt != LEAD_W'(LEAD)) lead_cnt <= lead_cnt + 1'b1;
            if (corr_valid) begin
                if (phase == PH_W'(SYM_LEN - 1)) begin
                    phase <= '0;
                    pass  <= pass + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
            if (final_pt) begin
                state    <= ACQ_IDLE;
                acq_done <= 1'b1;
            end
        end
    end

    fsync_corr #(
        .SAMP_W (SAMP_W),
        .LAG    (FFT_N),
        .WIN    (CP_LEN),
        .SUM_W  (SUM_W)
    ) corr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (acq_start),
        .en        (accept),
        .sample_in (smp_in),
        .corr_out  (corr)
    );

    fsync_fold #(
        .SYM_LEN (SYM_LEN),
        .IN_W    (SUM_W),
        .FOLD_W  (FOLD_W),
        .PH_W    (PH_W)
    ) fold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acq_start),
        .en       (corr_valid),
        .phase    (phase),
        .corr_in  (corr),
        .fold_out (folded)
    );

    fsync_peak #(
        .VAL_W   (FOLD_W),
        .SYM_LEN (SYM_LEN),
        .PH_W    (PH_W)
    ) peak_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acq_start),
        .en       (corr_valid && last_pass),
        .phase    (phase),
        .val      (folded),
        .peak_idx (sym_start_idx)
    );

    // R1: reset leaves the outputs cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!acq_done && sym_start_idx == '0));

    // R6: done only rises at the end of a running acquisition.
    a_r6_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_done) |-> $past(state == ACQ_RUN));

    // R7: after done the result holds until a new start.
    a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_done && !acq_start) |=> (acq_done && $stable(sym_start_idx)));

    // R8: a start strobe always drops done.
    a_r8_start_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !acq_done);

endmodule

// File: tb/fsync_top_tb_top.sv
// Bench for fsync_top: a behavioural reference model that works on a
// queue of accepted samples and is compared on every clock, plus
// directed patterns for the corner cases.
module fsync_top_tb_top;
    localparam int N     = 32;
    localparam int L     = 8;
    localparam int K     = 3;
    localparam int NS    = N + L;
    localparam int LEAD  = N + L - 1;
    localparam int TOTAL = LEAD + K*NS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acq_start = 1'b0;
    logic signed [7:0] smp_in = '0;
    logic [5:0]        sym_start_idx;
    logic              acq_done;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    int q[$];
    bit m_busy = 0;
    bit m_done = 0;
    int m_idx  = 0;
    int m_best = 0;
    int pat[TOTAL];

    always #4 clk = ~clk;   // 125 MHz

    fsync_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .acq_start     (acq_start),
        .smp_in        (smp_in),
        .sym_start_idx (sym_start_idx),
        .acq_done      (acq_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference update for one clock edge.
    function automatic void model_step(input bit st, input int x);
        if (st) begin
            q.delete();
            m_busy = 1; m_done = 0; m_idx = 0; m_best = 0;
        end else if (m_busy) begin
            int c;
            q.push_back(x);
            c = q.size() - 1;
            if (c >= LEAD) begin
                int m0, ph, f;
                m0 = c - LEAD;
                ph = m0 % NS;
                f  = m0 / NS;
                if (f == K - 1) begin
                    int fm, mag;
                    fm = 0;
                    for (int ff = 0; ff < K; ff++)
                        for (int j = 0; j < L; j++)
                            fm += q[ph + ff*NS + j] * q[ph + ff*NS + j + N];
                    mag = (fm < 0) ? -fm : fm;
                    if (ph == 0 || mag > m_best) begin
                        m_best = mag;
                        m_idx  = ph;
                    end
                    if (ph == NS - 1) begin
                        m_done = 1;
                        m_busy = 0;
                    end
                end
            end
        end
    endfunction

    // One clock: drive, let the edge happen, update the model, compare.
    task automatic step(input bit st, input int x);
        acq_start = st;
        smp_in    = 8'(x);
        @(posedge clk);
        model_step(st, x);
        @(negedge clk);
        chk(acq_done == m_done, "R6 done vs model", int'(acq_done), int'(m_done));
        chk(int'(sym_start_idx) == m_idx, "R5 index vs model (R2 R3 R4)",
            int'(sym_start_idx), m_idx);
    endtask

    // Start strobe (with a nonzero sample that must be ignored), then the pattern.
    task automatic play();
        step(1, 77);
        for (int i = 0; i < TOTAL; i++) step(0, pat[i]);
    endtask

    task automatic clear_pat();
        for (int i = 0; i < TOTAL; i++) pat[i] = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(acq_done == 1'b0, "R1 done in reset", int'(acq_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acq_done == 1'b0 && sym_start_idx == '0, "R1 state after reset",
            int'(sym_start_idx), 0);

        // R3: prefix copied FFT_N later; window start at offset 13.
        clear_pat();
        for (int j = 0; j < L; j++) begin
            pat[13 + j] = 50; pat[13 + j + N] = 50;
        end
        play();
        chk(int'(sym_start_idx) == 13, "R3 prefix peak", int'(sym_start_idx), 13);

        // R7: samples after done are ignored, result holds.
        for (int i = 0; i < 20; i++) step(0, 100 - 9*i);
        chk(acq_done && int'(sym_start_idx) == 13, "R7 hold after done",
            int'(sym_start_idx), 13);

        // R5: inverted copy gives a negative peak that must still win.
        clear_pat();
        for (int j = 0; j < L; j++) begin
            pat[27 + j] = 60; pat[27 + j + N] = -60;
            pat[3 + j]  = 20; pat[3 + j + N]  = 20;
        end
        play();
        chk(int'(sym_start_idx) == 27, "R5 negative magnitude peak",
            int'(sym_start_idx), 27);

        // R5: constant stream, every position ties, earliest wins.
        for (int i = 0; i < TOTAL; i++) pat[i] = 10;
        play();
        chk(int'(sym_start_idx) == 0, "R5 tie picks earliest", int'(sym_start_idx), 0);

        // R4: strong peak only in pass 0 beats weaker peak in passes 1 and 2.
        clear_pat();
        for (int j = 0; j < L; j++) begin
            pat[5 + j]   = 100; pat[5 + j + N]   = 100;
            pat[60 + j]  = 40;  pat[60 + j + N]  = 40;
            pat[100 + j] = 40;  pat[100 + j + N] = 40;
        end
        play();
        chk(int'(sym_start_idx) == 5, "R4 fold keeps first pass peak",
            int'(sym_start_idx), 5);

        // R6: done timing at the exact sample count.
        for (int i = 0; i < TOTAL; i++) pat[i] = (i * 37 % 200) - 100;
        step(1, 0);
        for (int i = 0; i < TOTAL - 1; i++) step(0, pat[i]);
        chk(acq_done == 1'b0, "R6 done low one sample early", int'(acq_done), 0);
        step(0, pat[TOTAL - 1]);
        chk(acq_done == 1'b1, "R6 done on last sample", int'(acq_done), 1);

        // R8: restart in mid-acquisition.
        step(1, 0);
        for (int i = 0; i < 70; i++) step(0, 90);
        step(1, 0);
        chk(acq_done == 1'b0, "R8 restart drops done", int'(acq_done), 0);
        clear_pat();
        for (int j = 0; j < L; j++) begin
            pat[31 + j] = -45; pat[31 + j + N] = -45;
        end
        for (int i = 0; i < TOTAL; i++) step(0, pat[i]);
        chk(acq_done && int'(sym_start_idx) == 31, "R8 result after restart",
            int'(sym_start_idx), 31);

        // R9: full-scale negative input, no wrap, all positions tie.
        for (int i = 0; i < TOTAL; i++) pat[i] = -128;
        play();
        chk(acq_done && int'(sym_start_idx) == 0, "R9 full scale", int'(sym_start_idx), 0);

        // Pseudo-random stream checked by the model on every clock.
        for (int i = 0; i < TOTAL; i++) pat[i] = int'($urandom_range(255)) - 128;
        play();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule